// File: doc/BRIEF.md
# Mode-Selectable 16-Bit Timer/Event Counter

A 16-bit up-counter driven by a count enable, with an 8-bit control register that chooses one of four clear/start behaviours. The counter can be parked at zero, left free-running, restarted from zero on a synchronized edge of an external input, or restarted when it reaches the value held in compare register 0. Both compare values arrive on input ports and are compared against the count on every enabled cycle.

A match against either compare value inverts a level output and raises a one-cycle interrupt pulse. The control register also carries a sticky overflow flag. This flag records every 0xFFFF to 0x0000 wrap, including the case where the restart-on-match value is itself 0xFFFF. The mode can leave the stopped state only by a write made while the counter is stopped. A write that selects stop is always accepted.

Top module: `evt_timer16`

## Requirements
- R1: After reset the control readback is 0x00, the count is 0, `tmr_out_o` is low and `irq_o` is low.
- R2: With mode 00 (stop) in the control field `ctrl_o[3:2]`, the count is forced to 0 on the next clock and stays there.
- R3: With mode 01 (free-running), the count advances by one on each clock where `cnt_en_i` is high, holds while it is low, and wraps from 0xFFFF to 0x0000.
- R4: With mode 10 (edge restart), a valid edge of `ext_i`, detected after a two-flop synchronizer, loads 0 into the count on the third clock after `ext_i` changes, even when `cnt_en_i` is low. `edge_sel_i` sets which edge is valid: 00 falling, 01 rising, 10 both, 11 none. Other transitions leave the count alone.
- R5: With mode 11 (match restart), the count goes to 0 on the clock after it equals `cmp0_i` while enabled, giving a period of `cmp0_i`+1 enabled clocks.
- R6: In any running mode, an enabled cycle whose count equals `cmp0_i` or `cmp1_i` inverts `tmr_out_o` on the next clock. It inverts only once when both values match on the same cycle.
- R7: Each such match cycle produces exactly one `irq_o` pulse, one clock wide, on the next clock. A cycle where both values match produces a single pulse.
- R8: The overflow flag `ctrl_o[0]` sets on any enabled count step from 0xFFFF to 0x0000 in a running mode, including mode 11 with `cmp0_i` = 0xFFFF. It stays set when 1 is written to bit 0. It clears when 0 is written to bit 0. A new overflow in the same cycle as a clearing write leaves it set.
- R9: A write changes the mode field only if the current mode is 00 or the written mode is 00. Other mode writes while running are ignored. Bit 1 and bits 7:4 always read 0.
- R10: Entering stop mode keeps the current level of `tmr_out_o`, and while stopped the output does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Control register write strobe |
| wr_data_i | input | 8 | Control register write data |
| cnt_en_i | input | 1 | Count enable |
| ext_i | input | 1 | External restart input, asynchronous |
| edge_sel_i | input | 2 | Valid edge select for `ext_i` |
| cmp0_i | input | 16 | Compare value 0 (also the restart value in mode 11) |
| cmp1_i | input | 16 | Compare value 1 |
| tmr_out_o | output | 1 | Toggling output |
| irq_o | output | 1 | Match interrupt pulse |
| ctrl_o | output | 8 | Control/status readback |
| count_o | output | 16 | Current count |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a software write that clears the overflow flag and a count wrap that sets it. The bench lets restart-on-match mode run with compare value 0xFFFF until the count reads 0xFFFF, then issues the clearing write on exactly the wrapping edge, and expects the flag to read back set. The second pair is a match on both compare values at once: with both values equal, the bench expects one inversion of the output and a single interrupt pulse that is low again on the following clock.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_STOP  = 2'b00,
    MODE_FREE  = 2'b01,
    MODE_EDGE  = 2'b10,
    MODE_MATCH = 2'b11
  } tmr_mode_e;

  typedef enum logic [1:0] {
    EDGE_FALL = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_BOTH = 2'b10,
    EDGE_NONE = 2'b11
  } tmr_edge_e;
endpackage

// File: rtl/tmr_edge_det.sv
module tmr_edge_det #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sig_i,
  input  logic [1:0] sel_i,
  output logic       edge_o
);
  import tmr_pkg::*;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   rise, fall;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[i] <= 1'b0;
        else if (i == 0) sync_q[i] <= sig_i;
        else sync_q[i] <= sync_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[SYNC_STAGES-1];
  end

  assign rise = sync_q[SYNC_STAGES-1] & ~prev_q;
  assign fall = ~sync_q[SYNC_STAGES-1] & prev_q;

  always_comb begin
    unique case (tmr_edge_e'(sel_i))
      EDGE_FALL: edge_o = fall;
      EDGE_RISE: edge_o = rise;
      EDGE_BOTH: edge_o = rise | fall;
      default:   edge_o = 1'b0;
    endcase
  end

  // R4: a reported edge implies the synchronized level moved
  p_edge_level_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o |-> (sync_q[SYNC_STAGES-1] != prev_q));
endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl #(
  parameter int unsigned CTRL_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CTRL_W-1:0] wr_data_i,
  input  logic              ovf_set_i,
  output tmr_pkg::tmr_mode_e mode_o,
  output logic              ovf_o,
  output logic [CTRL_W-1:0] ctrl_o
);
  import tmr_pkg::*;

  localparam int unsigned OVF_BIT  = 0;
  localparam int unsigned MODE_LSB = 2;
  localparam int unsigned PAD_W    = CTRL_W - MODE_LSB - 2;

  tmr_mode_e mode_q, wr_mode;
  logic      ovf_q, ovf_d, mode_we;

  assign wr_mode = tmr_mode_e'(wr_data_i[MODE_LSB +: 2]);
  // stop is always accepted; other mode changes only from stop
  assign mode_we = wr_en_i && (mode_q == MODE_STOP || wr_mode == MODE_STOP);

  always_comb begin
    ovf_d = ovf_q;
    if (wr_en_i && !wr_data_i[OVF_BIT]) ovf_d = 1'b0;
    if (ovf_set_i) ovf_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_STOP;
      ovf_q  <= 1'b0;
    end else begin
      ovf_q <= ovf_d;
      if (mode_we) mode_q <= wr_mode;
    end
  end

  assign mode_o = mode_q;
  assign ovf_o  = ovf_q;
  assign ctrl_o = {{PAD_W{1'b0}}, mode_q, 1'b0, ovf_q};

  p_ovf_set_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_set_i |=> ovf_q);
  p_ovf_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !(wr_en_i && !wr_data_i[OVF_BIT])) |=> ovf_q);
  p_mode_lock_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q != MODE_STOP && !(wr_en_i && wr_mode == MODE_STOP)) |=> $stable(mode_q));
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  tmr_pkg::tmr_mode_e mode_i,
  input  logic              en_i,
  input  logic              restart_i,
  input  logic [CNT_W-1:0]  cmp0_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              wrap_o
);
  import tmr_pkg::*;

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;

  assign cnt_inc = cnt_q + 1'b1;

  always_comb begin
    cnt_d = cnt_q;
    unique case (mode_i)
      MODE_STOP:  cnt_d = '0;
      MODE_FREE:  if (en_i) cnt_d = cnt_inc;
      MODE_EDGE: begin
        if (restart_i) cnt_d = '0;
        else if (en_i) cnt_d = cnt_inc;
      end
      MODE_MATCH: if (en_i) cnt_d = (cnt_q == cmp0_i) ? '0 : cnt_inc;
      default:    cnt_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  // covers the match-restart case with cmp0 at all ones
  assign wrap_o = (mode_i != MODE_STOP) && en_i && (cnt_q == CNT_MAX);
  assign cnt_o  = cnt_q;

  p_stop_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_STOP) |=> (cnt_q == '0));
  p_free_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_FREE && !en_i) |=> $stable(cnt_q));
  p_edge_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_EDGE && restart_i) |=> (cnt_q == '0));
  p_match_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_MATCH && en_i && cnt_q == cmp0_i) |=> (cnt_q == '0));
endmodule

// File: rtl/tmr_out_unit.sv
module tmr_out_unit #(
  parameter int unsigned CNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  tmr_pkg::tmr_mode_e mode_i,
  input  logic              en_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [CNT_W-1:0]  cmp0_i,
  input  logic [CNT_W-1:0]  cmp1_i,
  output logic              out_o,
  output logic              irq_o
);
  import tmr_pkg::*;

  logic hit0, hit1, hit_evt;
  logic out_q, irq_q;

  assign hit0    = (cnt_i == cmp0_i);
  assign hit1    = (cnt_i == cmp1_i);
  // a double hit collapses into one event
  assign hit_evt = (mode_i != MODE_STOP) && en_i && (hit0 || hit1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= hit_evt;
      if (hit_evt) out_q <= ~out_q;
    end
  end

  assign out_o = out_q;
  assign irq_o = irq_q;

  p_irq_toggle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> (out_q != $past(out_q)));
  p_toggle_once_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit0 && hit1 && en_i && mode_i != MODE_STOP) |=> (out_q != $past(out_q)));
  p_stop_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_STOP) |=> $stable(out_q));
endmodule

// File: rtl/evt_timer16.sv
module evt_timer16 #(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned CTRL_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CTRL_W-1:0] wr_data_i,
  input  logic              cnt_en_i,
  input  logic              ext_i,
  input  logic [1:0]        edge_sel_i,
  input  logic [CNT_W-1:0]  cmp0_i,
  input  logic [CNT_W-1:0]  cmp1_i,
  output logic              tmr_out_o,
  output logic              irq_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [CNT_W-1:0]  count_o
);
  import tmr_pkg::*;

  tmr_mode_e        mode;
  logic             ovf, wrap, ext_edge;
  logic [CNT_W-1:0] cnt;

  tmr_ctrl #(.CTRL_W(CTRL_W)) u_ctrl (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i,
    .ovf_set_i(wrap), .mode_o(mode), .ovf_o(ovf), .ctrl_o
  );

  tmr_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk_i, .rst_ni, .sig_i(ext_i), .sel_i(edge_sel_i), .edge_o(ext_edge)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .mode_i(mode), .en_i(cnt_en_i),
    .restart_i(ext_edge), .cmp0_i, .cnt_o(cnt), .wrap_o(wrap)
  );

  tmr_out_unit #(.CNT_W(CNT_W)) u_out (
    .clk_i, .rst_ni, .mode_i(mode), .en_i(cnt_en_i),
    .cnt_i(cnt), .cmp0_i, .cmp1_i, .out_o(tmr_out_o), .irq_o
  );

  assign count_o = cnt;

  p_flag_follows_wrap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf && !$past(ovf)) |-> ($past(count_o) == {CNT_W{1'b1}}));
  p_pad_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_o[CTRL_W-1:4] == '0) && !ctrl_o[1]);
endmodule

// File: tb/evt_timer16_test.sv
module evt_timer16_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [7:0]  wr_data_i = '0;
  logic        cnt_en_i = 1'b0;
  logic        ext_i = 1'b0;
  logic [1:0]  edge_sel_i = 2'b01;
  logic [15:0] cmp0_i = 16'h8000;
  logic [15:0] cmp1_i = 16'h9000;
  logic        tmr_out_o, irq_o;
  logic [7:0]  ctrl_o;
  logic [15:0] count_o;

  int checks = 0;
  int errors = 0;
  logic exp_out = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  evt_timer16 uut (
    .clk_i(clk), .rst_ni, .wr_en_i, .wr_data_i, .cnt_en_i, .ext_i,
    .edge_sel_i, .cmp0_i, .cmp1_i, .tmr_out_o, .irq_o, .ctrl_o, .count_o
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] d);
    wr_en_i = 1'b1; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 ctrl", 16'(ctrl_o), 16'h00);
    chk("R1 count", count_o, 16'h0);
    chk("R1 out", 16'(tmr_out_o), 16'h0);
    chk("R1 irq", 16'(irq_o), 16'h0);
  endtask

  task automatic t_free;
    cmp0_i = 16'h8000; cmp1_i = 16'h9000; cnt_en_i = 1'b1;
    wr(8'h04);
    chk("R3 start", count_o, 16'd0);
    tick(10);
    chk("R3 count", count_o, 16'd10);
    cnt_en_i = 1'b0; tick(3);
    chk("R3 hold", count_o, 16'd10);
    cnt_en_i = 1'b1;
    wr(8'h08);
    chk("R9 mode write ignored", 16'(ctrl_o), 16'h04);
    chk("R9 still counting", count_o, 16'd11);
    wr(8'h00);
    chk("R2 mode stop", 16'(ctrl_o), 16'h00);
    tick(1);
    chk("R2 zero", count_o, 16'd0);
    tick(2);
    chk("R2 held zero", count_o, 16'd0);
    wr(8'hF2);
    chk("R9 pad bits", 16'(ctrl_o), 16'h00);
    wr(8'hF6);
    chk("R9 mode from stop", 16'(ctrl_o), 16'h04);
    wr(8'h00); tick(1);
    chk("R10 out unchanged", 16'(tmr_out_o), 16'(exp_out));
  endtask

  task automatic t_match;
    cmp0_i = 16'd4; cmp1_i = 16'hFF00; cnt_en_i = 1'b1;
    wr(8'h0C);
    tick(4);
    chk("R5 at cmp", count_o, 16'd4);
    chk("R7 no irq yet", 16'(irq_o), 16'h0);
    tick(1); exp_out = ~exp_out;
    chk("R5 restart", count_o, 16'd0);
    chk("R6 toggle cmp0", 16'(tmr_out_o), 16'(exp_out));
    chk("R7 irq pulse", 16'(irq_o), 16'h1);
    tick(1);
    chk("R7 irq one cycle", 16'(irq_o), 16'h0);
    tick(3);
    chk("R5 period", count_o, 16'd4);
    tick(1); exp_out = ~exp_out;
    chk("R5 second restart", count_o, 16'd0);
    chk("R6 toggle back", 16'(tmr_out_o), 16'(exp_out));
    wr(8'h00); tick(1);
    // cmp1 alone
    cmp0_i = 16'd6; cmp1_i = 16'd2;
    wr(8'h0C); tick(2);
    chk("R6 before cmp1", 16'(tmr_out_o), 16'(exp_out));
    tick(1); exp_out = ~exp_out;
    chk("R6 toggle cmp1", 16'(tmr_out_o), 16'(exp_out));
    chk("R7 irq cmp1", 16'(irq_o), 16'h1);
    wr(8'h00); tick(1);
    // both at once
    cmp0_i = 16'd3; cmp1_i = 16'd3;
    wr(8'h0C); tick(3);
    chk("R5 at 3", count_o, 16'd3);
    tick(1); exp_out = ~exp_out;
    chk("R6 single toggle", 16'(tmr_out_o), 16'(exp_out));
    chk("R7 single irq", 16'(irq_o), 16'h1);
    tick(1);
    chk("R7 irq drops", 16'(irq_o), 16'h0);
    chk("R6 stays", 16'(tmr_out_o), 16'(exp_out));
    wr(8'h00); tick(3);
    chk("R10 out held in stop", 16'(tmr_out_o), 16'(exp_out));
    chk("R2 stop count", count_o, 16'd0);
  endtask

  task automatic t_edge;
    cmp0_i = 16'h8000; cmp1_i = 16'h9000; edge_sel_i = 2'b01;
    cnt_en_i = 1'b1;
    wr(8'h08); tick(5);
    chk("R4 counting", count_o, 16'd5);
    cnt_en_i = 1'b0; tick(1);
    ext_i = 1'b1; tick(2);
    chk("R4 sync delay", count_o, 16'd5);
    tick(1);
    chk("R4 rise clears", count_o, 16'd0);
    cnt_en_i = 1'b1; tick(4); cnt_en_i = 1'b0; tick(1);
    ext_i = 1'b0; tick(5);
    chk("R4 fall ignored", count_o, 16'd4);
    edge_sel_i = 2'b10;
    ext_i = 1'b1; tick(3);
    chk("R4 both edges", count_o, 16'd0);
    edge_sel_i = 2'b00;
    cnt_en_i = 1'b1; tick(2); cnt_en_i = 1'b0; tick(1);
    ext_i = 1'b0; tick(3);
    chk("R4 falling select", count_o, 16'd0);
    edge_sel_i = 2'b11;
    cnt_en_i = 1'b1; tick(2); cnt_en_i = 1'b0; tick(1);
    ext_i = 1'b1; tick(4);
    chk("R4 none select", count_o, 16'd2);
    wr(8'h00); tick(1);
  endtask

  task automatic t_ovf;
    cmp0_i = 16'hFFFF; cmp1_i = 16'hFFFF; cnt_en_i = 1'b1;
    wr(8'h04); tick(65535);
    chk("R3 at max", count_o, 16'hFFFF);
    chk("R8 no flag yet", 16'(ctrl_o), 16'h04);
    tick(1); exp_out = ~exp_out;
    chk("R3 wrap", count_o, 16'h0);
    chk("R8 flag set", 16'(ctrl_o), 16'h05);
    wr(8'h05);
    chk("R8 write one keeps", 16'(ctrl_o), 16'h05);
    wr(8'h04);
    chk("R8 write zero clears", 16'(ctrl_o), 16'h04);
    wr(8'h00); tick(1);
    wr(8'h0C); tick(65535);
    chk("R5 reaches max", count_o, 16'hFFFF);
    wr(8'h0C); exp_out = ~exp_out;
    chk("R8 set wins over clear", 16'(ctrl_o), 16'h0D);
    chk("R8 match wrap count", count_o, 16'h0);
    chk("R6 toggle at max", 16'(tmr_out_o), 16'(exp_out));
    wr(8'h0C);
    chk("R8 cleared", 16'(ctrl_o), 16'h0C);
    wr(8'h00); tick(1);
  endtask

  initial begin
    tick(2);
    rst_ni = 1'b1;
    tick(1);
    t_reset;
    t_free;
    t_match;
    t_edge;
    t_ovf;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule